// File: doc/BRIEF.md
# Poly1305 Key-Power Generator

This block takes the multiplier half of a Poly1305 one-time key, the value r, and fills a table with the powers r, r², r³, … r⁸. Each power is reduced modulo the prime 2^130 − 5. Parallel hash lanes use these powers to fold several 16-byte message words into one accumulator per step. Clamping r, hashing the message and adding the final key half all happen outside this block. Message data that arrives while the table is being built has to wait in a FIFO upstream. The generator can therefore work on the next key while an earlier message is still being hashed.

Four iterative modular multipliers form one bank. A scheduler runs them in doubling stages. Stage one squares r. Stage two forms r³ and r⁴ together. Stage three multiplies r⁴ by r, r², r³ and r⁴ to give r⁵ through r⁸. Every product is written back into the table as soon as it is available, and later stages take their operands from the table. All eight powers are therefore present after three multiply stages.

The r input uses a valid/ready handshake. A transfer happens on a rising clock edge where both `r_valid_i` and `r_ready_o` are high. `r_ready_o` is high only while the block is idle or finished. While the block is computing, a presented key is held back and has no effect. `done_o` is a plain level that stays high until the next key is accepted.

Top module: `keypow_gen`

## Requirements
- R1: A key is accepted only on an edge where `r_valid_i` and `r_ready_o` are both high. `r_ready_o` is high after reset and while `done_o` is high. It is low from the accepting edge until `done_o` rises.
- R2: Table entry 0 holds the accepted key reduced below the modulus p = 2^W − C (W = 130 and C = 5 by default). A key at or above p is stored as key − p.
- R3: When `done_o` is high, entry k (0-based, bits k·W to k·W+W−1 of `pow_o`) equals the stored key raised to the power k+1 modulo p. Every entry is below p.
- R4: On the edge that accepts a key, the valid vector drops to 1 (only entry 0 valid) and `done_o` falls.
- R5: Entries become valid in doubling prefixes. Bit k of `pow_vld_o` belongs to entry k. After acceptance the valid vector steps 1 → 3 → 15 → 255, with no other value in between. No entry is written twice per key.
- R6: `done_o` is high exactly when all entries are valid. It then holds, together with the table contents, until the next key is accepted. A key presented while `r_ready_o` is low leaves the results unchanged.
- R7: `done_o` rises exactly log2(NPOW)·(W+2) clock edges after the accepting edge. That is 396 edges by default and 45 with W = 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| r_valid_i | input | 1 | Key r is presented |
| r_ready_o | output | 1 | Block can take a key |
| r_i | input | W | Key r, already clamped by the user |
| done_o | output | 1 | All powers stored |
| pow_vld_o | output | NPOW | Per-entry valid bits |
| pow_o | output | NPOW·W | Power table, entry k at bits k·W upward |

## Verification
The bench builds two instances. The main one uses W = 13 and C = 5, so the modulus is 8187. At this size the bench can sweep more than a thousand keys, including 0, p−1, p, p+1 and 2^W−1, and check all eight powers of each against integer arithmetic. It also checks the exact cycle count and the valid-bit staging for every key, and it presents keys while the block is busy. The second instance keeps the default 130-bit configuration. A few keys, including one above the modulus, are checked against wide reference arithmetic done in the bench.

// File: rtl/poly_pow_pkg.sv
package poly_pow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } pow_state_e;
endpackage

// File: rtl/pp_modmul.sv
// Bit-serial modular multiplier: MSB-first double-and-add, W steps per product.
module pp_modmul #(
  parameter int W = 130,
  parameter int C = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] res_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W+1:0] P = {2'b01, {W{1'b0}}} - (W+2)'(C);

  logic [W-1:0]  a_q, b_q, acc_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W+1:0]  sum, red1, red2;

  // acc < p, so 2*acc + a < 3p: two conditional subtractions finish the reduction
  always_comb begin
    sum  = {1'b0, acc_q, 1'b0} + (b_q[W-1] ? {2'b00, a_q} : '0);
    red1 = (sum  >= P) ? sum  - P : sum;
    red2 = (red1 >= P) ? red1 - P : red1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        a_q    <= a_i;
        b_q    <= b_i;
        acc_q  <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= red2[W-1:0];
        b_q   <= {b_q[W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign res_o  = acc_q;

  assert_result_reduced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ({2'b00, res_o} < P));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/pp_table.sv
// Power table: NPOW entries with per-entry valid bits.
module pp_table #(
  parameter int W    = 130,
  parameter int NPOW = 8,
  parameter int NMUL = 4,
  localparam int IW  = $clog2(NPOW)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [W-1:0]              load_val_i,
  input  logic [NMUL-1:0]           wr_en_i,
  input  logic [NMUL-1:0][IW-1:0]   wr_idx_i,
  input  logic [NMUL-1:0][W-1:0]    wr_val_i,
  output logic [NPOW-1:0][W-1:0]    ent_o,
  output logic [NPOW-1:0]           vld_o
);
  logic [NPOW-1:0][W-1:0] ent_q;
  logic [NPOW-1:0]        vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      vld_q <= '0;
    end else if (load_i) begin
      ent_q[0] <= load_val_i;
      vld_q    <= NPOW'(1);
    end else begin
      for (int k = 0; k < NMUL; k++) begin
        if (wr_en_i[k]) begin
          ent_q[wr_idx_i[k]] <= wr_val_i[k];
          vld_q[wr_idx_i[k]] <= 1'b1;
        end
      end
    end
  end

  assign ent_o = ent_q;
  assign vld_o = vld_q;

  assert_clear_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (vld_o == NPOW'(1)));
  assert_prefix_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((vld_o & (vld_o + 1'b1)) == '0));

  for (genvar k = 0; k < NMUL; k++) begin : g_wchk
    assert_write_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i[k] && !load_i) |-> !vld_o[wr_idx_i[k]]);
  end
endmodule

// File: rtl/pp_sched.sv
// Doubling scheduler: stage s uses 2^s multipliers, operands from the table.
module pp_sched
  import poly_pow_pkg::*;
#(
  parameter int NPOW  = 8,
  localparam int NMUL = NPOW / 2,
  localparam int IW   = $clog2(NPOW),
  localparam int NSTG = $clog2(NPOW),
  localparam int SW   = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_i,
  input  logic [NMUL-1:0]         mul_done_i,
  output logic [NMUL-1:0]         mul_start_o,
  output logic [NMUL-1:0][IW-1:0] a_idx_o,
  output logic [NMUL-1:0][IW-1:0] b_idx_o,
  output logic [NMUL-1:0]         wr_en_o,
  output logic [NMUL-1:0][IW-1:0] wr_idx_o,
  output logic                    ready_o,
  output logic                    done_o
);
  pow_state_e      state_q;
  logic [SW-1:0]   stage_q;
  logic [NMUL-1:0] seen_q, act;
  logic [IW:0]     half;
  logic            all_in, last_stg;

  assign half     = (IW+1)'(1) << stage_q;
  assign last_stg = (stage_q == SW'(NSTG - 1));
  assign all_in   = (((seen_q | mul_done_i) & act) == act);

  for (genvar k = 0; k < NMUL; k++) begin : g_lane
    assign act[k]      = ((IW+1)'(k) < half);
    assign a_idx_o[k]  = IW'(half - 1'b1);
    assign b_idx_o[k]  = IW'(k);
    assign wr_idx_o[k] = IW'(half + (IW+1)'(k));
    assign wr_en_o[k]  = (state_q == ST_WAIT) && act[k] && mul_done_i[k];
  end

  assign mul_start_o = (state_q == ST_ISSUE) ? act : '0;
  assign ready_o     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      seen_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (acc_i) begin
            state_q <= ST_ISSUE;
            stage_q <= '0;
          end
        end
        ST_ISSUE: begin
          state_q <= ST_WAIT;
          seen_q  <= '0;
        end
        ST_WAIT: begin
          seen_q <= seen_q | mul_done_i;
          if (all_in) begin
            if (last_stg) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_ISSUE;
              stage_q <= stage_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_stage_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && all_in && !last_stg) |=>
      (state_q == ST_ISSUE && stage_q == $past(stage_q) + 1'b1));
  assert_start_onehot_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mul_start_o & (mul_start_o + 1'b1)) == '0));
endmodule

// File: rtl/keypow_gen.sv
module keypow_gen #(
  parameter int W    = 130,
  parameter int C    = 5,
  parameter int NPOW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              r_valid_i,
  output logic              r_ready_o,
  input  logic [W-1:0]      r_i,
  output logic              done_o,
  output logic [NPOW-1:0]   pow_vld_o,
  output logic [NPOW*W-1:0] pow_o
);
  localparam int NMUL = NPOW / 2;
  localparam int IW   = $clog2(NPOW);
  localparam logic [W:0] P = {1'b1, {W{1'b0}}} - (W+1)'(C);

  logic                    accept;
  logic [W:0]              r_ext;
  logic [W-1:0]            r_red;
  logic [NMUL-1:0]         mul_start, mul_done, mul_busy, wr_en;
  logic [NMUL-1:0][IW-1:0] a_idx, b_idx, wr_idx;
  logic [NMUL-1:0][W-1:0]  mul_res;
  logic [NPOW-1:0][W-1:0]  ent;

  assign accept = r_valid_i && r_ready_o;
  assign r_ext  = {1'b0, r_i};
  assign r_red  = (r_ext >= P) ? W'(r_ext - P) : r_i;

  pp_sched #(.NPOW(NPOW)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (accept),
    .mul_done_i  (mul_done),
    .mul_start_o (mul_start),
    .a_idx_o     (a_idx),
    .b_idx_o     (b_idx),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .ready_o     (r_ready_o),
    .done_o      (done_o)
  );

  for (genvar k = 0; k < NMUL; k++) begin : g_mul
    pp_modmul #(.W(W), .C(C)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (mul_start[k]),
      .a_i     (ent[a_idx[k]]),
      .b_i     (ent[b_idx[k]]),
      .busy_o  (mul_busy[k]),
      .done_o  (mul_done[k]),
      .res_o   (mul_res[k])
    );
  end

  pp_table #(.W(W), .NPOW(NPOW), .NMUL(NMUL)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept),
    .load_val_i (r_red),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_val_i   (mul_res),
    .ent_o      (ent),
    .vld_o      (pow_vld_o)
  );

  for (genvar i = 0; i < NPOW; i++) begin : g_out
    assign pow_o[i*W +: W] = ent[i];
  end

  assert_ready_when_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    r_ready_o |-> (mul_busy == '0));
  assert_accept_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!done_o && !r_ready_o && pow_vld_o == NPOW'(1)));
  assert_done_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (&pow_vld_o));
  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !r_valid_i) |=> (done_o && $stable(pow_o)));
endmodule

// File: tb/test_keypow_gen.sv
module test_keypow_gen;
  localparam int SW = 13;
  localparam int SC = 5;
  localparam longint SP = (64'd1 << SW) - SC;
  localparam int WW = 130;
  localparam logic [WW:0] WPX = {1'b1, {WW{1'b0}}} - (WW+1)'(5);
  localparam logic [WW-1:0] WP = WPX[WW-1:0];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic          s_valid = 1'b0;
  logic [SW-1:0] s_r = '0;
  logic          s_ready, s_done;
  logic [7:0]    s_vld;
  logic [8*SW-1:0] s_pow;

  logic          w_valid = 1'b0;
  logic [WW-1:0] w_r = '0;
  logic          w_ready, w_done;
  logic [7:0]    w_vld;
  logic [8*WW-1:0] w_pow;

  keypow_gen #(.W(SW), .C(SC), .NPOW(8)) i_keypow_gen (
    .clk(clk), .rst_n(rst_n), .r_valid_i(s_valid), .r_ready_o(s_ready),
    .r_i(s_r), .done_o(s_done), .pow_vld_o(s_vld), .pow_o(s_pow));

  keypow_gen i_keypow_gen_wide (
    .clk(clk), .rst_n(rst_n), .r_valid_i(w_valid), .r_ready_o(w_ready),
    .r_i(w_r), .done_o(w_done), .pow_vld_o(w_vld), .pow_o(w_pow));

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [WW-1:0] wmul(input logic [WW-1:0] a, input logic [WW-1:0] b);
    logic [2*WW-1:0] t;
    t = {{WW{1'b0}}, a} * {{WW{1'b0}}, b};
    t = t % {{WW{1'b0}}, WP};
    return t[WW-1:0];
  endfunction

  task automatic run_small(input longint rv, input bit poke);
    longint rm, x;
    int n, pos;
    bit bad;
    logic [7:0] seq [4];
    logic [8*SW-1:0] snap;
    seq[0] = 8'h01; seq[1] = 8'h03; seq[2] = 8'h0f; seq[3] = 8'hff;
    rm = (rv >= SP) ? rv - SP : rv;
    @(negedge clk);
    chk(s_ready == 1'b1, $sformatf("R1 ready before key %0d: actual %0b expected 1", rv, s_ready));
    s_r = SW'(rv);
    s_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_vld == 8'h01 && s_done == 1'b0,
        $sformatf("R4 after accept key %0d: actual vld %h done %0b expected 01 0", rv, s_vld, s_done));
    chk(longint'(s_pow[SW-1:0]) == rm,
        $sformatf("R2 entry0 key %0d: actual %0d expected %0d", rv, s_pow[SW-1:0], rm));
    n = 0; pos = 0; bad = 1'b0;
    while (n < 300) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (s_vld != seq[pos]) begin
        if (pos < 3 && s_vld == seq[pos+1]) pos++;
        else bad = 1'b1;
      end
      if (poke && n == 5) begin
        s_r = ~SW'(rv);
        s_valid = 1'b1;
      end
      if (poke && n == 20) s_valid = 1'b0;
      if (s_done) break;
      if (s_ready) bad = 1'b1;
    end
    chk(n == 3 * (SW + 2), $sformatf("R7 latency key %0d: actual %0d expected %0d", rv, n, 3 * (SW + 2)));
    chk(!bad && pos == 3, $sformatf("R5 staging key %0d: actual pos %0d bad %0b expected 3 0", rv, pos, bad));
    x = rm;
    for (int k = 0; k < 8; k++) begin
      chk(longint'(s_pow[k*SW +: SW]) == x,
          $sformatf("R3 key %0d power %0d: actual %0d expected %0d", rv, k + 1, s_pow[k*SW +: SW], x));
      x = (x * rm) % SP;
    end
    chk(s_ready == 1'b1, $sformatf("R1 ready after done key %0d: actual %0b expected 1", rv, s_ready));
    if (poke) begin
      snap = s_pow;
      repeat (3) @(negedge clk);
      chk(s_done == 1'b1 && s_pow == snap && s_vld == 8'hff,
          $sformatf("R6 hold key %0d: actual done %0b vld %h expected 1 ff", rv, s_done, s_vld));
    end
  endtask

  task automatic run_wide(input logic [WW-1:0] rv);
    logic [WW-1:0] rm, x;
    int n;
    rm = (rv >= WP) ? rv - WP : rv;
    @(negedge clk);
    w_r = rv;
    w_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    w_valid = 1'b0;
    chk(w_pow[WW-1:0] == rm, $sformatf("R2 wide entry0: actual %h expected %h", w_pow[WW-1:0], rm));
    n = 0;
    while (n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (w_done) break;
    end
    chk(n == 3 * (WW + 2), $sformatf("R7 wide latency: actual %0d expected %0d", n, 3 * (WW + 2)));
    x = rm;
    for (int k = 0; k < 8; k++) begin
      chk(w_pow[k*WW +: WW] == x,
          $sformatf("R3 wide power %0d: actual %h expected %h", k + 1, w_pow[k*WW +: WW], x));
      x = wmul(x, rm);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual cycles 190000 expected fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1 && s_done == 1'b0 && s_vld == 8'h00,
        $sformatf("R1 reset state: actual ready %0b done %0b vld %h expected 1 0 00", s_ready, s_done, s_vld));
    chk(w_ready == 1'b1 && w_done == 1'b0 && w_vld == 8'h00,
        $sformatf("R4 wide reset state: actual ready %0b done %0b vld %h expected 1 0 00", w_ready, w_done, w_vld));
    run_small(0, 1'b1);
    run_small(1, 1'b0);
    run_small(2, 1'b1);
    run_small(SP - 1, 1'b1);
    run_small(SP, 1'b0);
    run_small(SP + 1, 1'b1);
    run_small((64'd1 << SW) - 1, 1'b0);
    for (int j = 0; j < 1200; j++) run_small((longint'(j) * 7 + 3) % (64'd1 << SW), (j % 97) == 0);
    run_wide(130'd1);
    run_wide(130'h0_0f1e2d3c_0a5b6978_0c3d2e1f_05a4b3c2);
    run_wide(WP - 1);
    run_wide({WW{1'b1}});
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule